// File: doc/BRIEF.md
# Video Line-Rate Signal Detect Mute

This block decides whether a separated horizontal sync stream carries usable video. It then either passes four raw sync-derived signals through or holds them high. The sync input is resynchronised into the system clock domain, and each of its rising transitions becomes a one-cycle edge pulse. A counter measures the number of clock cycles between successive edges. An interval is a good line when it falls inside a tolerance window around the nominal line period. A bad line is an interval outside that window, or a gap longer than the window's upper bound.

A three-state controller adds hysteresis to that verdict. While enabled, one bad line starts a probation period. During probation the outputs keep passing their inputs. If a run of consecutive good lines arrives before the probation timer runs out, the controller goes back to enabled. If the timer expires first, every gated output is forced high and the mute flag is raised. Leaving the muted state needs the same run of consecutive good lines. After reset the block starts muted.

All timing is expressed in system-clock cycles. The nominal period defaults to 3175 cycles, which is a 63.5 µs line at 50 MHz, or about 15.74 kHz. The tolerance defaults to 50 per mille. The probation window defaults to 125000 cycles, which is 2.5 ms at 50 MHz.

Top module: `video_sigdet_mute`

## Requirements
- R1: Whenever `muted` is 0, including during probation, each of `csync_out`, `vsync_out`, `field_out` and `bporch_out` equals its matching raw input.
- R2: The window bounds are LO = LINE_CYC - LINE_CYC*TOL_PERMILLE/1000 and HI = LINE_CYC + LINE_CYC*TOL_PERMILLE/1000, both computed with integer division. Any of the following is a bad line: an interval below LO, an interval above HI, or a gap of more than HI cycles with no edge. While enabled, a bad line moves the block into probation, and the outputs keep passing their inputs.
- R3: If probation lasts PROB_CYC cycles without recovery, `muted` becomes 1 and all four gated outputs are driven to 1.
- R4: If GOOD_LINES consecutive good lines arrive during probation, the block returns to enabled and `muted` never rises.
- R5: When muted, the block re-enables after GOOD_LINES consecutive good lines. Intervals of exactly LO and exactly HI count as good. Any bad line resets the run count to zero.
- R6: The first edge after reset, and the first edge after a missing-edge timeout, only starts a new measurement and gives no verdict.
- R7: During and after reset, `muted` is 1 and all four gated outputs are 1.
- R8: `hsync_in` passes through SYNC_STAGES flops. Each rising transition produces exactly one edge, whatever the pulse width.
- R9: A bad line during probation does not restart the probation timer, which measures from the moment probation was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Separated horizontal sync, asynchronous |
| csync_in | input | 1 | Raw composite sync to gate |
| vsync_in | input | 1 | Raw vertical sync to gate |
| field_in | input | 1 | Raw odd/even field indicator to gate |
| bporch_in | input | 1 | Raw back-porch pulse to gate |
| csync_out | output | 1 | Gated composite sync |
| vsync_out | output | 1 | Gated vertical sync |
| field_out | output | 1 | Gated field indicator |
| bporch_out | output | 1 | Gated back-porch pulse |
| muted | output | 1 | High while the outputs are forced high |

## Verification
Several properties are checked by the assertions on every cycle:
- the output gating in both directions;
- probation can be entered only from enabled, and only on a bad line;
- muting happens only from probation, and only when the timer is at its last count;
- the timer steps by one for as long as probation lasts;
- the first edge after a disarm gives no verdict;
- each edge lasts exactly one cycle.

Other behaviour shows up only in the bench's scenarios. These cover the run of good lines needed to recover, a count reset by an interval just outside either bound, and recovery inside the probation window versus expiry. They also show that a timeout inside probation leaves the expiry time unchanged. A random phase mixes good and bad line lengths and pulse widths, and compares the mute state against a line-level model.

// File: rtl/vsdm_pkg.sv
package vsdm_pkg;

   typedef enum logic [1:0] {
      ST_MUTED     = 2'd0,
      ST_ENABLED   = 2'd1,
      ST_PROBATION = 2'd2
   } det_state_e;

   localparam int unsigned GATED_SIGNALS = 4;

endpackage

// File: rtl/vsdm_edge.sv
module vsdm_edge #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RISING      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_async,
   output logic edge_pulse
);

   localparam int unsigned MSB = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_sh;
   logic                   sync_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_sh   <= '0;
         sync_last <= 1'b0;
      end else begin
         sync_sh   <= {sync_sh[SYNC_STAGES-2:0], sync_async};
         sync_last <= sync_sh[MSB];
      end
   end

   generate
      if (RISING) begin : g_rise
         assign edge_pulse = sync_sh[MSB] & ~sync_last;
      end else begin : g_fall
         assign edge_pulse = ~sync_sh[MSB] & sync_last;
      end
   endgenerate

   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse |=> !edge_pulse); // R8

endmodule

// File: rtl/vsdm_line_meter.sv
module vsdm_line_meter #(
   parameter int unsigned LO_CYC = 190,
   parameter int unsigned HI_CYC = 210
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_pulse,
   output logic line_ok,
   output logic line_bad
);

   localparam int unsigned CW = $clog2(HI_CYC + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(HI_CYC);
   localparam logic [CW-1:0] LO_M1   = CW'(LO_CYC - 1);
   localparam logic [CW-1:0] HI_M1   = CW'(HI_CYC - 1);

   logic [CW-1:0] gap_cnt;
   logic          armed;
   logic          in_window;

   assign in_window = (gap_cnt >= LO_M1) && (gap_cnt <= HI_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt  <= '0;
         armed    <= 1'b0;
         line_ok  <= 1'b0;
         line_bad <= 1'b0;
      end else begin
         line_ok  <= 1'b0;
         line_bad <= 1'b0;
         if (edge_pulse) begin
            gap_cnt <= '0;
            armed   <= 1'b1;
            if (armed) begin
               line_ok  <= in_window;
               line_bad <= ~in_window;
            end
         end else begin
            if (gap_cnt != CNT_TOP) gap_cnt <= gap_cnt + 1'b1;
            if (armed && gap_cnt == HI_M1) begin
               line_bad <= 1'b1;
               armed    <= 1'b0;
            end
         end
      end
   end

   AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_ok && line_bad)); // R2
   AST_FIRST_EDGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(edge_pulse) && !$past(armed)) |-> (!line_ok && !line_bad)); // R6
   AST_OK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      line_ok |-> $past(edge_pulse)); // R5
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      gap_cnt <= CNT_TOP); // R2

endmodule

// File: rtl/vsdm_ctrl.sv
module vsdm_ctrl
   import vsdm_pkg::*;
#(
   parameter int unsigned PROB_CYC   = 125000,
   parameter int unsigned GOOD_LINES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_ok,
   input  logic       line_bad,
   output det_state_e state
);

   localparam int unsigned TW = (PROB_CYC > 1) ? $clog2(PROB_CYC) : 1;
   localparam int unsigned GW = $clog2(GOOD_LINES + 1);
   localparam logic [TW-1:0] TM_TOP = TW'(PROB_CYC - 1);
   localparam logic [GW-1:0] GC_TOP = GW'(GOOD_LINES - 1);

   det_state_e    st_nx;
   logic [TW-1:0] ptimer, tm_nx;
   logic [GW-1:0] gcnt, gc_nx;
   logic          run_done;

   assign run_done = line_ok && (gcnt == GC_TOP);

   always_comb begin
      st_nx = state;
      tm_nx = '0;
      gc_nx = gcnt;
      if (line_bad)
         gc_nx = '0;
      else if (line_ok && gcnt != GC_TOP)
         gc_nx = gcnt + 1'b1;
      case (state)
         ST_ENABLED: begin
            if (line_bad) st_nx = ST_PROBATION;
         end
         ST_PROBATION: begin
            if (run_done)              st_nx = ST_ENABLED;
            else if (ptimer == TM_TOP) st_nx = ST_MUTED;
            else                       tm_nx = ptimer + 1'b1;
         end
         ST_MUTED: begin
            if (run_done) st_nx = ST_ENABLED;
         end
         default: st_nx = ST_MUTED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_MUTED;
         ptimer <= '0;
         gcnt   <= '0;
      end else begin
         state  <= st_nx;
         ptimer <= tm_nx;
         gcnt   <= gc_nx;
      end
   end

   AST_PROB_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROBATION && $past(state) != ST_PROBATION)
         |-> ($past(state) == ST_ENABLED && $past(line_bad))); // R2
   AST_MUTE_AFTER_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MUTED && $past(state) == ST_PROBATION) |-> ($past(ptimer) == TM_TOP)); // R3
   AST_NO_DIRECT_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MUTED) |-> ($past(state) != ST_ENABLED)); // R3
   AST_ENABLE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ENABLED && $past(state) != ST_ENABLED) |-> $past(line_ok)); // R5
   AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_PROBATION) |-> (ptimer == '0)); // R9
   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROBATION && $past(state) == ST_PROBATION)
         |-> (ptimer == $past(ptimer) + 1'b1)); // R9

endmodule

// File: rtl/vsdm_gate.sv
module vsdm_gate #(
   parameter int unsigned N = 4
) (
   input  logic         mute,
   input  logic [N-1:0] raw,
   output logic [N-1:0] gated
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign gated[i] = mute | raw[i];
      end
   endgenerate

endmodule

// File: rtl/video_sigdet_mute.sv
module video_sigdet_mute
   import vsdm_pkg::*;
#(
   parameter int unsigned LINE_CYC     = 3175,
   parameter int unsigned TOL_PERMILLE = 50,
   parameter int unsigned PROB_CYC     = 125000,
   parameter int unsigned GOOD_LINES   = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          HS_RISING    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_in,
   input  logic csync_in,
   input  logic vsync_in,
   input  logic field_in,
   input  logic bporch_in,
   output logic csync_out,
   output logic vsync_out,
   output logic field_out,
   output logic bporch_out,
   output logic muted
);

   localparam int unsigned TOL_CYC = (LINE_CYC * TOL_PERMILLE) / 1000;
   localparam int unsigned LO_CYC  = LINE_CYC - TOL_CYC;
   localparam int unsigned HI_CYC  = LINE_CYC + TOL_CYC;

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (LINE_CYC < 16) begin : g_chk_line
         $error("LINE_CYC too small");
      end
      if (TOL_PERMILLE >= 500) begin : g_chk_tol
         $error("TOL_PERMILLE must be below 500");
      end
      if (PROB_CYC < 2) begin : g_chk_prob
         $error("PROB_CYC must be at least 2");
      end
      if (GOOD_LINES < 1) begin : g_chk_good
         $error("GOOD_LINES must be at least 1");
      end
   endgenerate

   logic       edge_pulse;
   logic       line_ok;
   logic       line_bad;
   det_state_e state;
   logic [GATED_SIGNALS-1:0] raw_vec;
   logic [GATED_SIGNALS-1:0] out_vec;

   vsdm_edge #(
      .SYNC_STAGES (SYNC_STAGES),
      .RISING      (HS_RISING)
   ) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_async (hsync_in),
      .edge_pulse (edge_pulse)
   );

   vsdm_line_meter #(
      .LO_CYC (LO_CYC),
      .HI_CYC (HI_CYC)
   ) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_pulse (edge_pulse),
      .line_ok    (line_ok),
      .line_bad   (line_bad)
   );

   vsdm_ctrl #(
      .PROB_CYC   (PROB_CYC),
      .GOOD_LINES (GOOD_LINES)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_ok  (line_ok),
      .line_bad (line_bad),
      .state    (state)
   );

   assign muted   = (state == ST_MUTED);
   assign raw_vec = {bporch_in, field_in, vsync_in, csync_in};

   vsdm_gate #(
      .N (GATED_SIGNALS)
   ) u_gate (
      .mute  (muted),
      .raw   (raw_vec),
      .gated (out_vec)
   );

   assign csync_out  = out_vec[0];
   assign vsync_out  = out_vec[1];
   assign field_out  = out_vec[2];
   assign bporch_out = out_vec[3];

   AST_PASS_WHEN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_MUTED) |-> ({bporch_out, field_out, vsync_out, csync_out} == raw_vec)); // R1
   AST_MUTE_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      muted |-> (&{bporch_out, field_out, vsync_out, csync_out})); // R3

endmodule

// File: tb/video_sigdet_mute_bench.sv
module video_sigdet_mute_bench;

   localparam int LINE = 200;
   localparam int TOLP = 50;
   localparam int PROB = 3000;
   localparam int GOOD = 8;
   localparam int LO   = LINE - (LINE * TOLP) / 1000;
   localparam int HI   = LINE + (LINE * TOLP) / 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync = 1'b0;
   logic [3:0] raw = '0;
   logic [3:0] outs;
   logic       muted;
   int         n_chk = 0;
   int         n_err = 0;

   always #10 clk = ~clk;

   video_sigdet_mute #(
      .LINE_CYC     (LINE),
      .TOL_PERMILLE (TOLP),
      .PROB_CYC     (PROB),
      .GOOD_LINES   (GOOD)
   ) u_video_sigdet_mute (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsync_in   (hsync),
      .csync_in   (raw[0]),
      .vsync_in   (raw[1]),
      .field_in   (raw[2]),
      .bporch_in  (raw[3]),
      .csync_out  (outs[0]),
      .vsync_out  (outs[1]),
      .field_out  (outs[2]),
      .bporch_out (outs[3]),
      .muted      (muted)
   );

   function automatic logic [4:0] expect_v(input bit m, input logic [3:0] r);
      return {m, (m ? 4'hF : r)};
   endfunction

   task automatic look(input string req, input bit exp_m);
      logic [4:0] act, exp;
      raw = 4'($urandom);
      #2;
      act = {muted, outs};
      exp = expect_v(exp_m, raw);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic line(input int per, input int wid, input bit do_chk,
                       input bit exp_m, input string req);
      for (int k = 0; k < per; k++) begin
         hsync = (k < wid);
         if (do_chk && k == 20) look(req, exp_m);
         @(negedge clk);
      end
   endtask

   // line-level reference model for the random phase
   typedef enum int {M_MUTED, M_EN, M_PROB} mstate_e;

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      mstate_e st;
      int      run, pentry, tnow, prev_per, per, wid, iv;
      bit      valid, skip, exp_m;
      void'($urandom(32'd20240611));

      // R7: reset state
      repeat (3) @(negedge clk);
      look("R7", 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      look("R7", 1'b1);

      // R6: first edge arms only; 8 edges give 7 good lines, still muted
      for (int i = 0; i < 8; i++) line(LINE, 5, 1'b0, 1'b0, "");
      look("R6", 1'b1);
      // R5: ninth edge completes the run
      line(LINE, 5, 1'b1, 1'b0, "R5");

      // R1: pass-through while enabled
      for (int i = 0; i < 3; i++) line(LINE, 7, 1'b1, 1'b0, "R1");

      // R4: short gap enters probation, recovery inside the window keeps outputs live
      line(170, 5, 1'b0, 1'b0, "");
      for (int i = 0; i < 30; i++) line(LINE, 5, 1'b1, 1'b0, "R4");

      // R2 / R3 / R9: bad line then silence; the later timeout must not restart the timer
      line(170, 5, 1'b0, 1'b0, "");
      hsync = 1'b1;
      repeat (5) @(negedge clk);
      hsync = 1'b0;
      repeat (2895) @(negedge clk);
      look("R2", 1'b0);
      repeat (200) @(negedge clk);
      look("R9", 1'b1);
      look("R3", 1'b1);

      // R5: boundaries HI and LO good, LO-1 resets the run
      for (int i = 0; i < 4; i++) line(HI, 5, 1'b0, 1'b0, "");
      line(LO - 1, 5, 1'b0, 1'b0, "");
      for (int i = 0; i < 7; i++) line(LO, 5, 1'b0, 1'b0, "");
      line(LO, 5, 1'b1, 1'b1, "R5");
      line(LINE, 5, 1'b1, 1'b0, "R5");

      // R3: silence from enabled leads to mute
      repeat (3300) @(negedge clk);
      look("R3", 1'b1);

      // R2 / R6: gap of HI+1 is bad and the edge after it only re-arms
      for (int i = 0; i < 4; i++) line(LINE, 5, 1'b0, 1'b0, "");
      line(HI + 1, 5, 1'b0, 1'b0, "");
      for (int i = 0; i < 7; i++) line(LINE, 5, 1'b0, 1'b0, "");
      line(LINE, 5, 1'b1, 1'b1, "R2");
      line(LINE, 5, 1'b1, 1'b0, "R6");

      // random phase with line-level model
      st = M_EN;
      run = GOOD;
      pentry = 0;
      tnow = 0;
      prev_per = LINE;
      for (int n = 0; n < 300; n++) begin
         iv = prev_per;
         valid = (iv >= LO) && (iv <= HI);
         run = valid ? ((run < GOOD) ? run + 1 : GOOD) : 0;
         skip = 1'b0;
         if (valid && run == GOOD) begin
            st = M_EN;
         end else if (!valid && st == M_EN) begin
            st = M_PROB;
            pentry = tnow;
         end else if (st == M_PROB && (tnow - pentry) > PROB - 15) begin
            st = M_MUTED;
            if (tnow + 20 - pentry < PROB + 20) skip = 1'b1;
         end
         if (st == M_PROB && (tnow + 20 - pentry) > PROB - 15) skip = 1'b1;
         exp_m = (st == M_MUTED);
         per = ($urandom_range(99, 0) < 75) ? int'($urandom_range(208, 192))
                                            : int'($urandom_range(180, 150));
         wid = int'($urandom_range(60, 1));
         line(per, wid, !skip, exp_m, "R8");
         prev_per = per;
         tnow += per;
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule